// File: doc/BRIEF.md
# Dual-Phase Interval Timer with Watchdog

This block holds two independent down-counting timers behind a simple register write bus with combinational readback. Every period of a timer is made of two phases: a low phase whose length comes from the timer's timeout count register, followed by a high phase whose length comes from its pulse count register. At the end of each complete period the timer raises a one-cycle interrupt. This serves periodic ticks, and it serves one-shot use when software reprograms the timer before the next expiry.

Software reprograms a timer by clearing its enable bit, writing both count registers and setting the enable bit again. Both counts are taken into the timer only at that rising edge of the enable. Timer 0 also has a watchdog mode, chosen by a marker code in the low byte of its timeout count register. In this mode the upper bits give a single countdown. When that countdown expires, the timer raises a reset request that stays high until the system reset.

Top module: `dual_phase_timer`

## Requirements
- R1: After reset all five registers read zero, and both waveforms, both interrupts and the reset request are low.
- R2: Register byte offsets: control 0x00, timer 1 timeout 0x04, timer 0 timeout 0x08, timer 1 pulse 0x0C, timer 0 pulse 0x10. Count registers read back their last 32-bit write. Control keeps only bits 1:0, and its other bits read zero. Any other offset reads zero.
- R3: Control bit 0 enables timer 0 and bit 1 enables timer 1. After the clock edge that sets the bit, the next edge starts the timer. Its waveform is then low for N cycles and high for P cycles, repeating with period N+P, where N is the timeout count and P is the pulse count.
- R4: A timer's interrupt is high for exactly the last cycle of each high phase, and at no other time.
- R5: A count of zero acts as one cycle, so both counts at zero give a period of 2 cycles.
- R6: Count registers written while a timer runs leave its waveform unchanged. The new values take effect at the next rising edge of the enable.
- R7: When an enable bit is cleared, that timer's waveform and interrupt are low from the cycle after the write, and the other timer keeps its timing.
- R8: If the low byte of timer 0's timeout register is 0xFF when timer 0 is enabled, timer 0 runs as a watchdog with count W = bits 31:8, where zero acts as one. The reset request rises W+1 cycles after the enabling edge. Timer 0's waveform and interrupt stay low in this mode.
- R9: Once raised, the reset request stays high, even after the enable is cleared, until rst_n is asserted.
- R10: Clearing timer 0's enable before the watchdog expires abandons the countdown, and re-enabling it restarts the full count.
- R11: Timer 1 has no watchdog mode: 0xFF in its timeout register is a plain count of 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tmr_wave | output | 2 | Per-timer waveform, high during the pulse phase |
| tmr_irq | output | 2 | Per-timer end-of-period pulse |
| wdog_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
Most internal faults show as a timing shift at the ports. A countdown that is off by one, or a phase decoded wrongly, moves a waveform edge or an interrupt. The error appears within the first period of N+P cycles after enable and grows each period after that. If a timer uses a live count register instead of the value it captured, the waveform changes one period after the running write, while the bench still expects the old timing. A watchdog fault shows as a reset request that rises early, rises late, rises at all after an aborted countdown, or drops before reset. The bench sees each of these within W+1 cycles.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  localparam int NUM_TMR = 2;

  // byte offsets of the register map
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_TMO1 = 'h04;
  localparam int OFF_TMO0 = 'h08;
  localparam int OFF_PLS1 = 'h0C;
  localparam int OFF_PLS0 = 'h10;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TMO,
    PH_PLS,
    PH_WDOG,
    PH_DEAD
  } phase_e;

endpackage

// File: rtl/dpt_regs.sv
module dpt_regs
  import dpt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [CNT_W-1:0]               wdata,
  output logic [CNT_W-1:0]               rdata,
  output logic [NUM_TMR-1:0]             en,
  output logic [NUM_TMR-1:0][CNT_W-1:0]  tmo,
  output logic [NUM_TMR-1:0][CNT_W-1:0]  pls
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_TMO0 = ADDR_W'(OFF_TMO0);
  localparam logic [ADDR_W-1:0] A_TMO1 = ADDR_W'(OFF_TMO1);
  localparam logic [ADDR_W-1:0] A_PLS0 = ADDR_W'(OFF_PLS0);
  localparam logic [ADDR_W-1:0] A_PLS1 = ADDR_W'(OFF_PLS1);

  logic [NUM_TMR-1:0]            ctrl_q;
  logic [NUM_TMR-1:0][CNT_W-1:0] tmo_q;
  logic [NUM_TMR-1:0][CNT_W-1:0] pls_q;

  // write decode, one register per offset
  logic hit_ctrl, hit_tmo0, hit_tmo1, hit_pls0, hit_pls1;
  assign hit_ctrl = wr && (addr == A_CTRL);
  assign hit_tmo0 = wr && (addr == A_TMO0);
  assign hit_tmo1 = wr && (addr == A_TMO1);
  assign hit_pls0 = wr && (addr == A_PLS0);
  assign hit_pls1 = wr && (addr == A_PLS1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tmo_q  <= '0;
      pls_q  <= '0;
    end else begin
      if (hit_ctrl) ctrl_q   <= wdata[NUM_TMR-1:0];
      if (hit_tmo0) tmo_q[0] <= wdata;
      if (hit_tmo1) tmo_q[1] <= wdata;
      if (hit_pls0) pls_q[0] <= wdata;
      if (hit_pls1) pls_q[1] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = CNT_W'(ctrl_q);
      A_TMO0:  rdata = tmo_q[0];
      A_TMO1:  rdata = tmo_q[1];
      A_PLS0:  rdata = pls_q[0];
      A_PLS1:  rdata = pls_q[1];
      default: rdata = '0;
    endcase
  end

  assign en  = ctrl_q;
  assign tmo = tmo_q;
  assign pls = pls_q;

  // R2
  wr_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctrl |=> (en == $past(wdata[NUM_TMR-1:0])));

endmodule

// File: rtl/dpt_chan.sv
module dpt_chan
  import dpt_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter bit HAS_WDOG     = 1'b0,
  parameter int WD_FIELD_LSB = 8,
  parameter logic [WD_FIELD_LSB-1:0] WD_CODE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] tmo_cnt,
  input  logic [CNT_W-1:0] pls_cnt,
  output logic             wave,
  output logic             irq,
  output logic             rst_req
);

  // reload value: a phase of v cycles starts with v-1, zero counts as one
  function automatic logic [CNT_W-1:0] first_tick(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] wd_len(input logic [CNT_W-1:0] v);
    return v >> WD_FIELD_LSB;
  endfunction

  function automatic logic is_wd_code(input logic [CNT_W-1:0] v);
    return HAS_WDOG && (v[WD_FIELD_LSB-1:0] == WD_CODE);
  endfunction

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tmo_hold;
  logic [CNT_W-1:0] pls_hold;
  logic             en_q;
  logic             rst_req_q;

  // named internal events
  logic en_rise, wd_sel, tmo_done, pls_done, wd_expire, cnt_zero;
  assign en_rise   = en && !en_q;
  assign wd_sel    = is_wd_code(tmo_cnt);
  assign cnt_zero  = (cnt == '0);
  assign tmo_done  = en && (phase == PH_TMO)  && cnt_zero;
  assign pls_done  = en && (phase == PH_PLS)  && cnt_zero;
  assign wd_expire = en && (phase == PH_WDOG) && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      tmo_hold  <= '0;
      pls_hold  <= '0;
      en_q      <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      en_q <= en;
      if (wd_expire) rst_req_q <= 1'b1;
      if (!en) begin
        phase <= PH_IDLE;
      end else if (en_rise) begin
        pls_hold <= pls_cnt;
        tmo_hold <= tmo_cnt;
        if (wd_sel) begin
          phase <= PH_WDOG;
          cnt   <= first_tick(wd_len(tmo_cnt));
        end else begin
          phase <= PH_TMO;
          cnt   <= first_tick(tmo_cnt);
        end
      end else begin
        case (phase)
          PH_TMO: begin
            if (cnt_zero) begin
              phase <= PH_PLS;
              cnt   <= first_tick(pls_hold);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          PH_PLS: begin
            if (cnt_zero) begin
              phase <= PH_TMO;
              cnt   <= first_tick(tmo_hold);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          PH_WDOG: begin
            if (cnt_zero) phase <= PH_DEAD;
            else          cnt   <= cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign wave    = en && (phase == PH_PLS);
  assign irq     = pls_done;
  assign rst_req = rst_req_q;

  // R4
  irq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4
  irq_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wave);

  // R3
  tmo_to_pls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_done |=> (phase == PH_PLS));

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == PH_IDLE));

  // R9
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  // R8
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(wd_expire));

  // R11
  no_wdog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_WDOG |-> (phase != PH_WDOG));

endmodule

// File: rtl/dual_phase_timer.sv
module dual_phase_timer
  import dpt_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int CNT_W        = 32,
  parameter int WD_FIELD_LSB = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CNT_W-1:0]    bus_wdata,
  output logic [CNT_W-1:0]    bus_rdata,
  output logic [NUM_TMR-1:0]  tmr_wave,
  output logic [NUM_TMR-1:0]  tmr_irq,
  output logic                wdog_rst_req
);

  logic [NUM_TMR-1:0]            en;
  logic [NUM_TMR-1:0][CNT_W-1:0] tmo;
  logic [NUM_TMR-1:0][CNT_W-1:0] pls;
  logic [NUM_TMR-1:0]            rst_vec;

  dpt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .en    (en),
    .tmo   (tmo),
    .pls   (pls)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    dpt_chan #(
      .CNT_W        (CNT_W),
      .HAS_WDOG     (i == 0),
      .WD_FIELD_LSB (WD_FIELD_LSB)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en[i]),
      .tmo_cnt (tmo[i]),
      .pls_cnt (pls[i]),
      .wave    (tmr_wave[i]),
      .irq     (tmr_irq[i]),
      .rst_req (rst_vec[i])
    );
  end

  assign wdog_rst_req = |rst_vec;

endmodule

// File: tb/dual_phase_timer_test.sv
module dual_phase_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  tmr_wave;
  logic [1:0]  tmr_irq;
  logic        wdog_rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dual_phase_timer uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .tmr_wave     (tmr_wave),
    .tmr_irq      (tmr_irq),
    .wdog_rst_req (wdog_rst_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int span(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // caller sits just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, "readback", bus_rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // k counts edges since the enabling write edge
  task automatic run_pair(input int t0, p0, input bit on0,
                          input int t1, p1, input bit on1,
                          input int k0, cnt, input string req);
    for (int k = k0 + 1; k <= k0 + cnt; k++) begin
      logic [1:0] ew, ei;
      int n0 = span(t0), q0 = span(p0), n1 = span(t1), q1 = span(p1);
      int s0 = (k - 1) % (n0 + q0), s1 = (k - 1) % (n1 + q1);
      @(negedge clk);
      ew[0] = on0 && (s0 >= n0);
      ei[0] = on0 && (s0 == n0 + q0 - 1);
      ew[1] = on1 && (s1 >= n1);
      ei[1] = on1 && (s1 == n1 + q1 - 1);
      chk(req, "wave", {30'b0, tmr_wave}, {30'b0, ew});
      chk(req, "irq",  {30'b0, tmr_irq},  {30'b0, ei});
      chk(req, "rst_req", {31'b0, wdog_rst_req}, 32'd0);
    end
  endtask

  task automatic wd_window(input int w, k0, cnt, input string req);
    for (int k = k0 + 1; k <= k0 + cnt; k++) begin
      @(negedge clk);
      chk(req, "rst_req", {31'b0, wdog_rst_req}, {31'b0, k >= span(w) + 1});
      chk(req, "t0 quiet", {30'b0, tmr_wave[0], tmr_irq[0]}, 32'd0);
    end
  endtask

  task automatic t_reset();
    rd_chk("R1", 5'h00, 0); rd_chk("R1", 5'h04, 0); rd_chk("R1", 5'h08, 0);
    rd_chk("R1", 5'h0C, 0); rd_chk("R1", 5'h10, 0);
    chk("R1", "outputs", {27'b0, tmr_wave, tmr_irq, wdog_rst_req}, 32'd0);
  endtask

  task automatic t_regmap();
    wr(5'h04, 32'h1111_0004); wr(5'h08, 32'h2222_0008);
    wr(5'h0C, 32'h3333_000C); wr(5'h10, 32'h4444_0010);
    wr(5'h00, 32'hFFFF_FFFC);
    rd_chk("R2", 5'h04, 32'h1111_0004); rd_chk("R2", 5'h08, 32'h2222_0008);
    rd_chk("R2", 5'h0C, 32'h3333_000C); rd_chk("R2", 5'h10, 32'h4444_0010);
    rd_chk("R2", 5'h00, 32'h0);
    rd_chk("R2", 5'h14, 32'h0);
    wr(5'h00, 32'h0000_0003); rd_chk("R2", 5'h00, 32'h3);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_basic();
    wr(5'h04, 3); wr(5'h0C, 5); wr(5'h00, 2);
    run_pair(0, 0, 0, 3, 5, 1, 0, 24, "R3 R4");
    wr(5'h00, 0);
  endtask

  task automatic t_min();
    wr(5'h08, 0); wr(5'h10, 0); wr(5'h00, 1);
    run_pair(0, 0, 1, 0, 0, 0, 0, 10, "R5");
    wr(5'h00, 0);
  endtask

  task automatic t_capture();
    wr(5'h08, 2); wr(5'h10, 3); wr(5'h00, 1);
    run_pair(2, 3, 1, 0, 0, 0, 0, 4, "R6");
    wr(5'h08, 4); wr(5'h10, 1);
    run_pair(2, 3, 1, 0, 0, 0, 6, 14, "R6");
    rd_chk("R6", 5'h08, 32'd4);
    wr(5'h00, 0); wr(5'h00, 1);
    run_pair(4, 1, 1, 0, 0, 0, 0, 12, "R6");
    wr(5'h00, 0);
  endtask

  task automatic t_stop();
    wr(5'h08, 2); wr(5'h10, 2); wr(5'h04, 1); wr(5'h0C, 1);
    wr(5'h00, 3);
    run_pair(2, 2, 1, 1, 1, 1, 0, 6, "R7");
    wr(5'h00, 1);
    run_pair(2, 2, 1, 1, 1, 0, 7, 10, "R7");
    wr(5'h00, 0);
    run_pair(0, 0, 0, 0, 0, 0, 0, 5, "R7");
  endtask

  task automatic t_wdog();
    wr(5'h08, (32'd6 << 8) | 32'hFF); wr(5'h00, 1);
    wd_window(6, 0, 4, "R10");
    wr(5'h00, 0); wr(5'h00, 1);
    wd_window(6, 0, 10, "R8");
    wr(5'h00, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9", "rst_req held", {31'b0, wdog_rst_req}, 32'd1);
    end
    do_reset();
    chk("R9", "rst_req after reset", {31'b0, wdog_rst_req}, 32'd0);
  endtask

  task automatic t_t1_plain();
    wr(5'h04, 32'hFF); wr(5'h0C, 2); wr(5'h00, 2);
    run_pair(0, 0, 0, 255, 2, 1, 0, 262, "R11");
    wr(5'h00, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_regmap();
    t_basic();
    t_min();
    t_capture();
    t_stop();
    t_wdog();
    t_t1_plain();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule